// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block is a calendar counter for real time. A 32768 Hz tick enable, qualified by a run control, drives a seconds prescaler. On each whole second the block advances six packed BCD fields: seconds, minutes, hours (24-hour), day of month, month and a two-digit year that stands for 2000 to 2099. Day rollover follows the month length. February gets 29 days whenever the year is a multiple of four.

Each second advance is reported by a one-cycle strobe. Further strobes mark the minute, hour and day boundaries. The running time is compared against a six-field alarm value, and an alarm strobe is raised only when every field matches exactly. The comparison happens once per second advance. Any field can be written directly through a per-field load enable. Loading the seconds field restarts the prescaler, so the next advance comes one full second after the load.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, day 01, month 01, year 00, and all strobes are low.
- R2: With run high, the seconds field advances once per TICKS_PER_SEC clock cycles that have tick_en high. Cycles with tick_en low do not count.
- R3: Seconds and minutes count in BCD from 00 to 59 and then wrap to 00. Hours count from 00 to 23 and then wrap to 00. Each wrap carries into the next field, and a BCD ones digit of 9 carries into the tens digit.
- R4: ev_sec pulses for one cycle together with each second advance. ev_min pulses when seconds wrap, ev_hour when minutes wrap, and ev_day when hours wrap. Each strobe appears in the same cycle as the updated fields.
- R5: Day wraps back to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February. The wrap advances the month.
- R6: In February, day wraps after 29 if the BCD year is divisible by four (this includes 00), and after 28 otherwise.
- R7: Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00.
- R8: While run is low the fields, the prescaler and the strobes are all frozen. When run returns high, counting resumes from the prescaler count that was held.
- R9: Bit i of ld_en writes byte i of ld_time into field i at the next edge, whether run is high or low. The field order is 0 seconds, 1 minutes, 2 hours, 3 day, 4 month, 5 year, with byte i at bits 8i+7..8i. Fields not selected keep their value. A cycle with any load does not advance the prescaler. Loading seconds clears the prescaler.
- R10: ev_alarm pulses for one cycle when a second advance makes all six fields equal to alm_time, which uses the same byte order. If any one field differs, no pulse is raised.
- R11: A load, or time standing still at a value that equals the alarm, raises no ev_alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle pulse at the 32768 Hz rate |
| run | input | 1 | High lets the clock advance, low freezes it |
| ld_en | input | 6 | Per-field load enables, bit 0 seconds to bit 5 year |
| ld_time | input | 48 | Load values, byte i for field i, packed BCD |
| alm_time | input | 48 | Alarm values, byte i for field i, packed BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD 00-23 |
| day_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month, BCD 01-12 |
| year_o | output | 8 | Year, BCD 00-99 |
| ev_sec | output | 1 | Second advance strobe |
| ev_min | output | 1 | Minute boundary strobe |
| ev_hour | output | 1 | Hour boundary strobe |
| ev_day | output | 1 | Day boundary strobe |
| ev_alarm | output | 1 | Alarm match strobe |

## Verification
The assertions take it for granted that every value written through ld_time is a legal calendar value in BCD. For example, no ones digit above 9, no hour above 23, and no day beyond the length of the month. They also assume that alm_time holds still around the second advance that it is compared against. The stimulus loads only legal dates. It changes the alarm only in cycles that cannot advance, while tick_en is low or a load is taking place. It also runs the prescaler at four ticks per second, so that every wrap path is reached in a few cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELDS = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;

  typedef logic [7:0] bcd8_t;

  // Lowest legal value of each field.
  function automatic bcd8_t field_lo(int idx);
    return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  // Highest legal value of each field; the day limit is supplied at run time.
  function automatic bcd8_t field_hi(int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  function automatic bcd8_t bcd_inc(bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic clr,
  output logic step
);
  localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    step  = adv && !clr && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = '0;
    else if (adv)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: a seconds load leaves the prescaler at zero
  a_r9_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  // R8: no advance and no clear, count holds
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  bcd8_t mon,
  input  bcd8_t year,
  output bcd8_t last_day
);
  logic [6:0] year_bin;
  logic       leap;

  always_comb begin
    year_bin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    leap     = (year_bin[1:0] == 2'b00);
    case (mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
(
  input  bcd8_t cur,
  input  bcd8_t lo,
  input  bcd8_t hi,
  input  logic  inc,
  output bcd8_t nxt,
  output logic  wrap
);
  always_comb begin
    wrap = inc && (cur == hi);
    if (!inc)     nxt = cur;
    else if (wrap) nxt = lo;
    else           nxt = bcd_inc(cur);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        run,
  input  logic [5:0]  ld_en,
  input  logic [47:0] ld_time,
  input  logic [47:0] alm_time,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic [7:0]  day_o,
  output logic [7:0]  mon_o,
  output logic [7:0]  year_o,
  output logic        ev_sec,
  output logic        ev_min,
  output logic        ev_hour,
  output logic        ev_day,
  output logic        ev_alarm
);
  localparam logic [47:0] RESET_TIME = 48'h00_01_01_00_00_00;

  // reset synchroniser: asserts at once, releases on the clock
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic [NFIELDS-1:0][7:0] time_q, time_d, cnt_nxt;
  logic [NFIELDS-1:0]      inc, wrap;
  logic [4:0]              ev_q, ev_d;
  logic                    any_ld, adv, step;
  bcd8_t                   last_day;

  assign any_ld = |ld_en;
  assign adv    = tick_en && run && !any_ld;

  rtc_prescaler #(.TICKS(TICKS_PER_SEC)) u_presc (
    .clk  (clk),
    .rst_n(rst_s),
    .adv  (adv),
    .clr  (ld_en[F_SEC]),
    .step (step)
  );

  rtc_month_len u_mlen (
    .mon     (time_q[F_MON]),
    .year    (time_q[F_YEAR]),
    .last_day(last_day)
  );

  assign inc[0] = step;

  for (genvar i = 0; i < NFIELDS; i++) begin : g_field
    bcd8_t hi_w;
    if (i == F_DAY) begin : g_dyn
      assign hi_w = last_day;
    end else begin : g_fix
      assign hi_w = field_hi(i);
    end
    rtc_bcd_field u_fld (
      .cur (time_q[i]),
      .lo  (field_lo(i)),
      .hi  (hi_w),
      .inc (inc[i]),
      .nxt (cnt_nxt[i]),
      .wrap(wrap[i])
    );
    if (i < NFIELDS - 1) begin : g_carry
      assign inc[i+1] = wrap[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NFIELDS; i++)
      time_d[i] = ld_en[i] ? ld_time[i*8 +: 8] : cnt_nxt[i];
    ev_d[0] = step;
    ev_d[1] = wrap[F_SEC];
    ev_d[2] = wrap[F_MIN];
    ev_d[3] = wrap[F_HOUR];
    ev_d[4] = step && (time_d == alm_time);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      time_q <= RESET_TIME;
      ev_q   <= '0;
    end else begin
      time_q <= time_d;
      ev_q   <= ev_d;
    end
  end

  assign sec_o    = time_q[F_SEC];
  assign min_o    = time_q[F_MIN];
  assign hour_o   = time_q[F_HOUR];
  assign day_o    = time_q[F_DAY];
  assign mon_o    = time_q[F_MON];
  assign year_o   = time_q[F_YEAR];
  assign ev_sec   = ev_q[0];
  assign ev_min   = ev_q[1];
  assign ev_hour  = ev_q[2];
  assign ev_day   = ev_q[3];
  assign ev_alarm = ev_q[4];

  // R4: boundary strobes nest inside the finer ones
  a_r4_min_in_sec: assert property (@(posedge clk) disable iff (!rst_s)
    ev_min |-> ev_sec);
  a_r4_hour_in_min: assert property (@(posedge clk) disable iff (!rst_s)
    ev_hour |-> ev_min);
  a_r4_day_in_hour: assert property (@(posedge clk) disable iff (!rst_s)
    ev_day |-> ev_hour);
  a_r4_min_at_zero: assert property (@(posedge clk) disable iff (!rst_s)
    ev_min |-> (sec_o == 8'h00));
  a_r4_sec_single: assert property (@(posedge clk) disable iff (!rst_s)
    ev_sec |=> !ev_sec);
  // R3: seconds stay legal BCD (given legal loads)
  a_r3_sec_legal: assert property (@(posedge clk) disable iff (!rst_s)
    (sec_o[3:0] <= 4'd9) && (sec_o <= 8'h59));
  // R8: stopped and not loading, time holds
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_s)
    (!run && ld_en == '0) |=> $stable(time_q));
  // R10: alarm strobe means exact match with the alarm value compared
  a_r10_exact: assert property (@(posedge clk) disable iff (!rst_s)
    ev_alarm |-> (time_q == $past(alm_time)));
  // R11: alarm only accompanies a second advance
  a_r11_on_step: assert property (@(posedge clk) disable iff (!rst_s)
    ev_alarm |-> ev_sec);
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  localparam int TPS = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, run;
  logic [5:0]  ld_en;
  logic [47:0] ld_time, alm_time;
  logic [7:0]  sec_o, min_o, hour_o, day_o, mon_o, year_o;
  logic        ev_sec, ev_min, ev_hour, ev_day, ev_alarm;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(TPS)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run),
    .ld_en(ld_en), .ld_time(ld_time), .alm_time(alm_time),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .day_o(day_o),
    .mon_o(mon_o), .year_o(year_o), .ev_sec(ev_sec), .ev_min(ev_min),
    .ev_hour(ev_hour), .ev_day(ev_day), .ev_alarm(ev_alarm)
  );

  function automatic logic [47:0] now();
    return {year_o, mon_o, day_o, hour_o, min_o, sec_o};
  endfunction
  function automatic logic [4:0] evs();
    return {ev_alarm, ev_day, ev_hour, ev_min, ev_sec};
  endfunction

  task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at falling edge, the next falling edge shows the result
  task automatic cyc(logic t, logic r, logic [5:0] le, logic [47:0] lt);
    tick_en = t; run = r; ld_en = le; ld_time = lt;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [47:0] start;
    logic [47:0] alarm;
    logic [47:0] expt;
    logic [4:0]  ev;   // {alarm, day, hour, min, sec}
  } vec_t;

  localparam logic [47:0] NOAL = 48'h98_12_31_23_59_58;
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{48'h24_01_01_00_00_00, NOAL, 48'h24_01_01_00_00_01, 5'b00001}, // R3
    '{48'h24_05_15_12_34_09, NOAL, 48'h24_05_15_12_34_10, 5'b00001}, // R3 digit
    '{48'h24_01_01_00_00_59, NOAL, 48'h24_01_01_00_01_00, 5'b00011}, // R4
    '{48'h24_01_01_00_59_59, NOAL, 48'h24_01_01_01_00_00, 5'b00111}, // R4
    '{48'h24_01_01_19_59_59, NOAL, 48'h24_01_01_20_00_00, 5'b00111}, // R3 hour
    '{48'h24_01_01_23_59_59, NOAL, 48'h24_01_02_00_00_00, 5'b01111}, // R4 day
    '{48'h24_01_31_23_59_59, NOAL, 48'h24_02_01_00_00_00, 5'b01111}, // R5
    '{48'h24_04_30_23_59_59, NOAL, 48'h24_05_01_00_00_00, 5'b01111}, // R5
    '{48'h24_06_30_23_59_59, NOAL, 48'h24_07_01_00_00_00, 5'b01111}, // R5
    '{48'h24_07_30_23_59_59, NOAL, 48'h24_07_31_00_00_00, 5'b01111}, // R5
    '{48'h24_11_30_23_59_59, NOAL, 48'h24_12_01_00_00_00, 5'b01111}, // R5
    '{48'h24_02_28_23_59_59, NOAL, 48'h24_02_29_00_00_00, 5'b01111}, // R6
    '{48'h24_02_29_23_59_59, NOAL, 48'h24_03_01_00_00_00, 5'b01111}, // R6
    '{48'h23_02_28_23_59_59, NOAL, 48'h23_03_01_00_00_00, 5'b01111}, // R6
    '{48'h00_02_28_23_59_59, NOAL, 48'h00_02_29_00_00_00, 5'b01111}, // R6
    '{48'h10_02_28_23_59_59, NOAL, 48'h10_03_01_00_00_00, 5'b01111}, // R6
    '{48'h12_02_28_23_59_59, NOAL, 48'h12_02_29_00_00_00, 5'b01111}, // R6
    '{48'h24_12_31_23_59_59, NOAL, 48'h25_01_01_00_00_00, 5'b01111}, // R7
    '{48'h99_12_31_23_59_59, NOAL, 48'h00_01_01_00_00_00, 5'b01111}, // R7
    '{48'h24_05_15_12_34_09, 48'h24_05_15_12_34_10,
      48'h24_05_15_12_34_10, 5'b10001},                              // R10
    '{48'h24_05_15_12_34_09, 48'h25_05_15_12_34_10,
      48'h24_05_15_12_34_10, 5'b00001},                              // R10 year off
    '{48'h24_03_31_23_59_59, 48'h24_04_01_00_00_00,
      48'h24_04_01_00_00_00, 5'b11111}                               // R10 at day wrap
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [4:0] acc;
    rst_n = 1'b0; tick_en = 1'b0; run = 1'b0; ld_en = '0;
    ld_time = '0; alm_time = NOAL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 time", now(), 48'h00_01_01_00_00_00);
    chk("R1 strobes", 48'(evs()), 48'h0);

    // table walk: load, then exactly one second of ticks
    for (int v = 0; v < NV; v++) begin
      alm_time = VEC[v].alarm;
      cyc(0, 1, 6'h3f, VEC[v].start);
      for (int k = 0; k < TPS; k++) cyc(1, 1, 6'h00, '0);
      chk($sformatf("R3-R10 vec%0d time", v), now(), VEC[v].expt);
      chk($sformatf("R4/R10 vec%0d strobes", v), 48'(evs()), 48'(VEC[v].ev));
    end

    // R10: alarm pulse lasts one cycle
    cyc(1, 1, 6'h00, '0);
    chk("R10 alarm width", 48'(evs()), 48'h0);

    // R2: tick_en low does not count
    alm_time = NOAL;
    cyc(0, 1, 6'h3f, 48'h24_05_15_12_34_00);
    repeat (10) cyc(0, 1, 6'h00, '0);
    chk("R2 no tick", now(), 48'h24_05_15_12_34_00);
    for (int k = 0; k < TPS - 1; k++) cyc(1, 1, 6'h00, '0);
    chk("R2 short", now(), 48'h24_05_15_12_34_00);
    cyc(1, 1, 6'h00, '0);
    chk("R2 full second", now(), 48'h24_05_15_12_34_01);

    // R8: stop holds fields and prescaler
    cyc(1, 1, 6'h00, '0);
    cyc(1, 1, 6'h00, '0);
    acc = '0;
    for (int k = 0; k < 10; k++) begin
      cyc(1, 0, 6'h00, '0);
      acc |= evs();
    end
    chk("R8 frozen time", now(), 48'h24_05_15_12_34_01);
    chk("R8 no strobes", 48'(acc), 48'h0);
    cyc(1, 1, 6'h00, '0);
    chk("R8 resume held count", now(), 48'h24_05_15_12_34_01);
    cyc(1, 1, 6'h00, '0);
    chk("R8 resume advance", now(), 48'h24_05_15_12_34_02);

    // R9: seconds load clears prescaler, others untouched
    for (int k = 0; k < TPS - 1; k++) cyc(1, 1, 6'h00, '0);
    cyc(1, 1, 6'h01, 48'h77_77_77_77_77_30);
    chk("R9 sec load", now(), 48'h24_05_15_12_34_30);
    for (int k = 0; k < TPS - 1; k++) cyc(1, 1, 6'h00, '0);
    chk("R9 prescaler cleared", now(), 48'h24_05_15_12_34_30);
    cyc(1, 1, 6'h00, '0);
    chk("R9 one second after load", now(), 48'h24_05_15_12_34_31);
    cyc(0, 0, 6'h10, 48'h77_09_77_77_77_77);
    chk("R9 load while stopped", now(), 48'h24_09_15_12_34_31);

    // R11: loading onto the alarm value, then standing still, no alarm
    alm_time = 48'h24_06_01_08_00_00;
    cyc(0, 1, 6'h3f, 48'h24_06_01_08_00_00);
    acc = evs();
    for (int k = 0; k < 5; k++) begin
      cyc(1, 0, 6'h00, '0);
      acc |= evs();
    end
    chk("R11 no alarm on load/hold", 48'(acc), 48'h0);
    alm_time = 48'h24_06_01_08_00_01;
    for (int k = 0; k < TPS; k++) cyc(1, 1, 6'h00, '0);
    chk("R10 alarm after hold", 48'(evs()), 48'h11);
    acc = '0;
    for (int k = 0; k < TPS; k++) begin
      cyc(1, 1, 6'h00, '0);
      acc |= {evs()[4], 4'b0};
    end
    chk("R11 no repeat alarm", 48'(acc), 48'h0);
    chk("R11 time moved on", now(), 48'h24_06_01_08_00_02);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule